// File: doc/BRIEF.md
# Receive descriptor ring writer

This block is the device half of a receive descriptor ring that lives in a word-addressed memory shared with a host. Once reception is enabled, it loads its descriptor pointer from a base-address input and reads descriptors in turn. A descriptor is four consecutive 32-bit words. The status word sits at the descriptor address, the control word at +1, the buffer address at +2, and a link word at +3 that the block leaves unused. When the host has marked a descriptor as device-owned, the block stores one incoming byte-stream frame into that descriptor's buffer. It then writes a status word back, which clears ownership and reports the length and error summary.

Descriptors are taken one after another in memory. A flag in the control word sends the pointer back to the base after the current descriptor. If the block finds a descriptor the host still holds, it suspends and waits for a poll request. Input is back-pressured through a ready signal, so no byte is lost while the block is fetching, closing or suspended. The memory port is a single synchronous request interface: read data returns on the cycle after the request.

Top module: `rxring_writer`

## Requirements
- R1: After reset, and for as long as `run_en` stays low in the stopped state, `rx_state` reads 0, `in_ready` is 0 and `mem_req` is 0.
- R2: When `run_en` is sampled high in the stopped state, the pointer is loaded from `ring_base`. The next memory access is a read of that address. Status is at the descriptor address, control at +1 and the buffer address at +2.
- R3: Status bit 31 set means device-owned. If bit 31 is clear, the block enters the suspended state (`rx_state` = 4). While suspended it makes no memory access and holds `in_ready` low. Each `poll_req` pulse re-reads the same descriptor.
- R4: Frame byte k is written to word `buffer + k/4`, in bits `8*(k%4)+7 : 8*(k%4)`, so bytes are packed little-endian. Byte lanes of the final word that received no byte are written as zero.
- R5: Control bits 10:0 give the buffer size in bytes. Bytes with index at or beyond the size are not stored and their lanes are zero. A word whose first byte index is at or beyond the size is not written. Any discarded byte sets the error summary.
- R6: After the last byte (`in_last`) of a frame, the status word is written back with bit 31 = 0, bits 30:16 = number of bytes received (all bytes, including the trailing check sequence), bit 15 = error summary, bit 8 = 1 and all other bits 0. The write happens two cycles after the last byte is accepted. The error summary is the OR of `in_err` over every byte of the frame and of any size overflow.
- R7: After write-back, the next descriptor is at the current address + 4. If the current descriptor's control bit 25 is set, the next descriptor is at `ring_base` instead.
- R8: Lowering `run_en` during a frame has no effect until that frame's status is written back; the block then stops (`rx_state` = 0). Lowering it while waiting for a frame that has not begun stops at once and leaves the fetched descriptor unwritten.
- R9: `rx_state` encodes 1 = fetching a descriptor, 2 = ready for or receiving a frame, 3 = closing a frame. `in_ready` is high only in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Reception enable (level) |
| poll_req | input | 1 | Host poll pulse, resumes a suspended walk |
| ring_base | input | ADDR_W | Word address of the first descriptor |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Error flag for this byte |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_state | output | 3 | Receive process state code |

## Verification
The bench covers several corner cases, each aimed at a specific fault:
- A one-byte frame and a frame that fills exactly one word. A packer that drops a partial final word, or misplaces a lane, fails here.
- A frame seven bytes longer than a ten-byte buffer, followed by one exactly the buffer size. A design with an off-by-one in the size compare either writes past the buffer into a sentinel word or flags a spurious error.
- The end-of-ring descriptor is followed by a frame, which shows whether the pointer returns to the base or runs off the ring.
- A non-owned descriptor, probed with offered input and a poll made before the host re-arms it. A faulty design would swallow bytes or write an unowned descriptor.
- Lowering `run_en` in the middle of a frame, and again while idle. A faulty design would abandon the status write or corrupt the next descriptor.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int WORD_W     = 32;
  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 25;
  localparam int ES_BIT     = 15;
  localparam int LS_BIT     = 8;
  localparam int LEN_LSB    = 16;
  localparam int LEN_W      = 15;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    DS_STOP, DS_RD_ST, DS_RD_CT, DS_RD_BF, DS_LD_BF,
    DS_RECV, DS_GAP, DS_WB, DS_SUSP
  } desc_st_e;

  typedef enum logic [2:0] {
    RXS_STOPPED = 3'd0,
    RXS_FETCH   = 3'd1,
    RXS_RECV    = 3'd2,
    RXS_CLOSE   = 3'd3,
    RXS_SUSP    = 3'd4
  } rx_state_e;
endpackage

// File: rtl/rxring_packer.sv
module rxring_packer
  import rxring_pkg::*;
#(
  parameter int SIZE_W = 11,
  localparam int OFF_W = LEN_W - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                accept,
  input  logic [7:0]          byte_i,
  input  logic                last_i,
  input  logic                err_i,
  input  logic [SIZE_W-1:0]   size_i,
  output logic [LEN_W-1:0]    len_o,
  output logic                started_o,
  output logic                err_sum_o,
  output logic                wr_pend_o,
  output logic [OFF_W-1:0]    wr_off_o,
  output logic [WORD_W-1:0]   wr_data_o
);
  localparam logic [LEN_W-1:0] IDX_MAX = '1;

  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              err_q, err_d;
  logic              ovf_q, ovf_d;
  logic              pend_q, pend_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [WORD_W-1:0] data_q, data_d;

  logic [LEN_W-1:0]  size_ext;
  logic [LEN_W-1:0]  word_first;
  logic [1:0]        lane;
  logic              keep;
  logic              word_hit;
  logic              word_end;
  logic [WORD_W-1:0] acc_ins;
  logic              upd;

  assign size_ext   = LEN_W'(size_i);
  assign lane       = idx_q[1:0];
  assign keep       = idx_q < size_ext;
  assign word_first = {idx_q[LEN_W-1:2], 2'b00};
  assign word_hit   = word_first < size_ext;
  assign word_end   = (lane == 2'd3) || last_i;
  assign upd        = clr || accept;

  always_comb begin
    acc_ins = acc_q;
    for (int b = 0; b < 4; b++) begin
      if (keep && (lane == 2'(b))) acc_ins[8*b +: 8] = byte_i;
    end
  end

  always_comb begin
    idx_d  = idx_q;
    acc_d  = acc_q;
    err_d  = err_q;
    ovf_d  = ovf_q;
    pend_d = 1'b0;
    off_d  = off_q;
    data_d = data_q;
    if (clr) begin
      idx_d = '0;
      acc_d = '0;
      err_d = 1'b0;
      ovf_d = 1'b0;
    end else if (accept) begin
      idx_d = (idx_q == IDX_MAX) ? idx_q : idx_q + LEN_W'(1);
      err_d = err_q | err_i;
      ovf_d = ovf_q | ~keep;
      if (word_end) begin
        pend_d = word_hit;
        off_d  = idx_q[LEN_W-1:2];
        data_d = acc_ins;
        acc_d  = '0;
      end else begin
        acc_d  = acc_ins;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      acc_q  <= '0;
      err_q  <= 1'b0;
      ovf_q  <= 1'b0;
      off_q  <= '0;
      data_q <= '0;
    end else if (upd) begin
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      err_q  <= err_d;
      ovf_q  <= ovf_d;
      off_q  <= off_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign len_o     = idx_q;
  assign started_o = idx_q != '0;
  assign err_sum_o = err_q | ovf_q;
  assign wr_pend_o = pend_q;
  assign wr_off_o  = off_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/rxring_fsm.sv
module rxring_fsm
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                poll_req,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic [WORD_W-1:0]   rd_data,
  input  logic                accept,
  input  logic                last_i,
  input  logic                started_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                err_sum_i,
  output logic                rq_req,
  output logic                rq_we,
  output logic [ADDR_W-1:0]   rq_addr,
  output logic [WORD_W-1:0]   rq_wdata,
  output logic                in_ready_o,
  output logic                pk_clr,
  output logic [SIZE_W-1:0]   size_o,
  output logic [ADDR_W-1:0]   buf_o,
  output logic [2:0]          rx_state_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_WORDS);

  desc_st_e          st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              eor_q, eor_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [WORD_W-1:0] close_word;

  always_comb begin
    close_word                      = '0;
    close_word[LEN_LSB +: LEN_W]    = len_i;
    close_word[ES_BIT]              = err_sum_i;
    close_word[LS_BIT]              = 1'b1;
    close_word[OWN_BIT]             = 1'b0;
  end

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    size_d     = size_q;
    eor_d      = eor_q;
    buf_d      = buf_q;
    rq_req     = 1'b0;
    rq_we      = 1'b0;
    rq_addr    = cur_q;
    rq_wdata   = '0;
    pk_clr     = 1'b0;
    in_ready_o = 1'b0;
    unique case (st_q)
      DS_STOP: begin
        if (run_en) begin
          cur_d = ring_base;
          st_d  = DS_RD_ST;
        end
      end
      DS_RD_ST: begin
        if (!run_en) begin
          st_d = DS_STOP;
        end else begin
          rq_req = 1'b1;
          st_d   = DS_RD_CT;
        end
      end
      DS_RD_CT: begin
        if (!rd_data[OWN_BIT]) begin
          st_d = DS_SUSP;
        end else begin
          rq_req  = 1'b1;
          rq_addr = cur_q + ADDR_W'(1);
          st_d    = DS_RD_BF;
        end
      end
      DS_RD_BF: begin
        size_d  = rd_data[SIZE_W-1:0];
        eor_d   = rd_data[EOR_BIT];
        rq_req  = 1'b1;
        rq_addr = cur_q + ADDR_W'(2);
        st_d    = DS_LD_BF;
      end
      DS_LD_BF: begin
        buf_d  = rd_data[ADDR_W-1:0];
        pk_clr = 1'b1;
        st_d   = DS_RECV;
      end
      DS_RECV: begin
        in_ready_o = run_en | started_i;
        if (accept && last_i)          st_d = DS_GAP;
        else if (!run_en && !started_i) st_d = DS_STOP;
      end
      DS_GAP: begin
        st_d = DS_WB;
      end
      DS_WB: begin
        rq_req   = 1'b1;
        rq_we    = 1'b1;
        rq_wdata = close_word;
        cur_d    = eor_q ? ring_base : cur_q + STRIDE;
        st_d     = DS_RD_ST;
      end
      DS_SUSP: begin
        if (!run_en)       st_d = DS_STOP;
        else if (poll_req) st_d = DS_RD_ST;
      end
      default: st_d = DS_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DS_STOP;
      cur_q  <= '0;
      size_q <= '0;
      eor_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      size_q <= size_d;
      eor_q  <= eor_d;
      buf_q  <= buf_d;
    end
  end

  always_comb begin
    unique case (st_q)
      DS_STOP:                               rx_state_o = RXS_STOPPED;
      DS_RD_ST, DS_RD_CT, DS_RD_BF, DS_LD_BF: rx_state_o = RXS_FETCH;
      DS_RECV:                               rx_state_o = RXS_RECV;
      DS_GAP, DS_WB:                         rx_state_o = RXS_CLOSE;
      DS_SUSP:                               rx_state_o = RXS_SUSP;
      default:                               rx_state_o = RXS_STOPPED;
    endcase
  end

  assign size_o = size_q;
  assign buf_o  = buf_q;
endmodule

// File: rtl/rxring_memmux.sv
module rxring_memmux
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 13
) (
  input  logic                pk_pend,
  input  logic [OFF_W-1:0]    pk_off,
  input  logic [WORD_W-1:0]   pk_data,
  input  logic [ADDR_W-1:0]   buf_base,
  input  logic                rq_req,
  input  logic                rq_we,
  input  logic [ADDR_W-1:0]   rq_addr,
  input  logic [WORD_W-1:0]   rq_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata
);
  always_comb begin
    if (pk_pend) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = buf_base + ADDR_W'(pk_off);
      mem_wdata = pk_data;
    end else begin
      mem_req   = rq_req;
      mem_we    = rq_we;
      mem_addr  = rq_addr;
      mem_wdata = rq_wdata;
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                poll_req,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  input  logic                in_last,
  input  logic                in_err,
  output logic                in_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic [2:0]          rx_state
);
  localparam int OFF_W = LEN_W - 2;

  logic              accept;
  logic              pk_clr;
  logic [SIZE_W-1:0] size_w;
  logic [ADDR_W-1:0] buf_w;
  logic [LEN_W-1:0]  len_w;
  logic              started_w;
  logic              err_sum_w;
  logic              pend_w;
  logic [OFF_W-1:0]  off_w;
  logic [WORD_W-1:0] pdata_w;
  logic              rq_req, rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [WORD_W-1:0] rq_wdata;

  assign accept = in_valid & in_ready;

  rxring_fsm #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_req(poll_req),
    .ring_base(ring_base), .rd_data(mem_rdata), .accept(accept),
    .last_i(in_last), .started_i(started_w), .len_i(len_w),
    .err_sum_i(err_sum_w), .rq_req(rq_req), .rq_we(rq_we),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata), .in_ready_o(in_ready),
    .pk_clr(pk_clr), .size_o(size_w), .buf_o(buf_w), .rx_state_o(rx_state)
  );

  rxring_packer #(.SIZE_W(SIZE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .accept(accept),
    .byte_i(in_data), .last_i(in_last), .err_i(in_err), .size_i(size_w),
    .len_o(len_w), .started_o(started_w), .err_sum_o(err_sum_w),
    .wr_pend_o(pend_w), .wr_off_o(off_w), .wr_data_o(pdata_w)
  );

  rxring_memmux #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_mux (
    .pk_pend(pend_w), .pk_off(off_w), .pk_data(pdata_w), .buf_base(buf_w),
    .rq_req(rq_req), .rq_we(rq_we), .rq_addr(rq_addr), .rq_wdata(rq_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              poll_req,
  input logic [ADDR_W-1:0] ring_base,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [2:0]        rx_state
);
  // R1: stopped and disabled means no traffic and no readiness
  a_r1_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd0 && !run_en) |-> (!mem_req && !in_ready));

  // R2: first access after a start is a read of the ring base
  a_r2_start_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd0 && run_en) |=>
      (!run_en || (mem_req && !mem_we && mem_addr == $past(ring_base))));

  // R3: suspended walk touches nothing
  a_r3_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd4) |-> (!mem_req && !in_ready));

  // R6: closing write two cycles after the last byte clears ownership
  a_r6_close_status: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> ##1
      (mem_req && mem_we && !mem_wdata[31] && mem_wdata[8]));

  // R8: a frame once begun keeps the block receiving
  a_r8_frame_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=> (rx_state == 3'd2 && in_ready));

  // R9: readiness only in the receiving state
  a_r9_ready_in_recv: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (rx_state == 3'd2));

  // R3: poll outside suspension leaves the state code alone when stopped
  a_r3_poll_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd0 && !run_en && poll_req) |=> (rx_state == 3'd0));
endmodule

bind rxring_writer rxring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_req(poll_req),
  .ring_base(ring_base), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_state(rx_state)
);

// File: tb/tb_rxring_writer.sv
module tb_rxring_writer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 16;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam int BASE = 'h100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, run_en, poll_req;
  logic [AW-1:0] ring_base;
  logic          in_valid, in_last, in_err;
  logic [7:0]    in_data;
  logic          in_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [2:0]    rx_state;

  rxring_writer #(.ADDR_W(AW), .SIZE_W(11)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_req(poll_req),
    .ring_base(ring_base), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_state(rx_state)
  );

  logic [31:0] mem [0:4095];
  logic        host_we;
  logic [11:0] host_addr;
  logic [31:0] host_data;

  always @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_data;
    if (mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:0]];
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] fb [0:255];
  int sz [0:3];
  int ptr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    host_addr = 12'(a);
    host_data = d;
    host_we   = 1'b1;
    @(posedge clk);
    #1;
    host_we   = 1'b0;
  endtask

  function automatic int desc_addr(input int d);
    return BASE + 4 * d;
  endfunction

  function automatic int buf_addr(input int d);
    return 'h400 + 'h40 * d;
  endfunction

  task automatic arm(input int d);
    for (int w = 0; w < 20; w++) host_wr(buf_addr(d) + w, SENT);
    host_wr(desc_addr(d) + 1, 32'(sz[d]) | ((d == 3) ? 32'h0200_0000 : 32'h0));
    host_wr(desc_addr(d) + 2, 32'(buf_addr(d)));
    host_wr(desc_addr(d) + 3, 32'h0);
    host_wr(desc_addr(d), 32'h8000_0000);
  endtask

  function automatic logic [31:0] exp_word(input int w, input int n, input int size);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      int k = 4 * w + b;
      if (k < n && k < size) r[8*b +: 8] = fb[k];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_status(input int n, input bit err, input int size);
    logic [31:0] r = '0;
    r[30:16] = 15'(n);
    r[15]    = err || (n > size);
    r[8]     = 1'b1;
    return r;
  endfunction

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom_range(0, 255));
  endtask

  task automatic send(input int n, input int errpos, input int stop_at);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      if (i == stop_at) run_en = 1'b0;
      if ($urandom_range(0, 7) == 0) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = fb[i];
        in_last  = (i == n - 1);
        in_err   = (i == errpos);
        if (in_ready) i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_err   = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(input int d, input int n, input bit err, input string req);
    int kept = (n < sz[d]) ? n : sz[d];
    int nw = (kept + 3) / 4;
    bit ok = 1;
    logic [31:0] a = '0, e = '0;
    chk(mem[desc_addr(d)] == exp_status(n, err, sz[d]), {req, " R6 status"},
        mem[desc_addr(d)], exp_status(n, err, sz[d]));
    for (int w = 0; w < nw; w++) begin
      if (ok && mem[buf_addr(d) + w] !== exp_word(w, n, sz[d])) begin
        ok = 0; a = mem[buf_addr(d) + w]; e = exp_word(w, n, sz[d]);
      end
    end
    chk(ok, {req, " R4 buffer"}, a, e);
    chk(mem[buf_addr(d) + nw] == SENT, {req, " R5 no write past data"},
        mem[buf_addr(d) + nw], SENT);
  endtask

  task automatic frame(input int n, input int errpos, input string req);
    int d = ptr;
    fill(n);
    send(n, errpos, -1);
    check_frame(d, n, errpos >= 0, req);
    arm(d);
    ptr = (ptr == 3) ? 0 : ptr + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int ep;
    void'($urandom(32'h5EED_1234));
    sz[0] = 200; sz[1] = 200; sz[2] = 10; sz[3] = 200;
    rst_n = 1'b1; run_en = 1'b0; poll_req = 1'b0; ring_base = AW'(BASE);
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_err = 1'b0;
    host_we = 1'b0; host_addr = '0; host_data = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_state == 3'd0 && !in_ready && !mem_req, "R1 in reset",
        {29'd0, rx_state}, 32'd0);
    rst_n = 1'b1;
    for (int d = 0; d < 4; d++) arm(d);
    @(negedge clk);
    chk(rx_state == 3'd0 && !in_ready && !mem_req, "R1 after reset",
        {29'd0, rx_state}, 32'd0);

    run_en = 1'b1;
    repeat (8) @(negedge clk);
    chk(rx_state == 3'd2 && in_ready, "R2 R9 ready after fetch",
        {29'd0, rx_state}, 32'd2);

    frame(1, -1, "R4 one byte");
    frame(23, 5, "R6 error mid frame");
    frame(17, -1, "R5 overflow");
    frame(4, -1, "R7 end of ring desc");
    frame(31, -1, "R7 wrapped to base");
    n = $urandom_range(5, 60);
    frame(n, -1, "R4 random");

    // R3: clear ownership of descriptor 3, then fill descriptor 2 exactly
    host_wr(desc_addr(3), 32'h0);
    frame(10, -1, "R5 exact size");
    repeat (4) @(negedge clk);
    chk(rx_state == 3'd4, "R3 suspended", {29'd0, rx_state}, 32'd4);
    begin
      bit quiet = 1;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
        if (in_ready || mem_req) quiet = 0;
      end
      in_valid = 1'b0; in_last = 1'b0;
      chk(quiet, "R3 no traffic while suspended", {31'd0, quiet}, 32'd1);
    end
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    repeat (8) @(negedge clk);
    chk(rx_state == 3'd4, "R3 poll on unowned", {29'd0, rx_state}, 32'd4);
    arm(3);
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    repeat (8) @(negedge clk);
    chk(rx_state == 3'd2, "R3 resumed by poll", {29'd0, rx_state}, 32'd2);
    frame(26, -1, "R3 after resume");

    // R8: stop during a frame on descriptor 0
    fill(20);
    send(20, -1, 3);
    check_frame(0, 20, 1'b0, "R8 frame finished after stop");
    chk(rx_state == 3'd0 && !in_ready, "R8 stopped after close",
        {29'd0, rx_state}, 32'd0);
    chk(mem[desc_addr(1)][31], "R8 next desc untouched", mem[desc_addr(1)],
        32'h8000_0000);
    arm(0);
    ptr = 0;
    run_en = 1'b1;
    repeat (8) @(negedge clk);
    frame(9, -1, "R2 restart at base");
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_state == 3'd0 && !in_ready, "R8 idle stop",
        {29'd0, rx_state}, 32'd0);
    chk(mem[desc_addr(1)] == 32'h8000_0000, "R8 idle desc still owned",
        mem[desc_addr(1)], 32'h8000_0000);

    // random frames after a restart from the base
    ptr = 0;
    run_en = 1'b1;
    for (int f = 0; f < 16; f++) begin
      n  = $urandom_range(1, 60);
      ep = ($urandom_range(0, 3) == 0) ? $urandom_range(0, n - 1) : -1;
      frame(n, ep, "R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule